// File: doc/BRIEF.md
# UART Interrupt Mask and Sticky Status Bank

This block collects the thirteen interrupt causes of a UART and turns them into a single interrupt request line. Each cycle the UART core presents a vector of one-cycle event pulses. Every pulse is latched into a sticky status bit. The status bit stays set until software clears it by writing a one to that bit.

A separate mask decides which latched causes may raise the interrupt line. Software never writes the mask directly. It has a set-only port, where each one bit enables a source, and a clear-only port, where each one bit disables a source. The current mask can be read back but not written. The interrupt output is high whenever any status bit is set together with its mask bit.

All register accesses are single-cycle write strobes with data. The mask and status values are always visible on read ports.

Top module: `irq_bank`

## Requirements
- R1: Reset (synchronous, active high) clears every mask bit and every status bit, and the interrupt output is low afterwards.
- R2: A write on the enable port sets each mask bit whose data bit is 1, one clock after the strobe. Mask bits whose data bit is 0 keep their value.
- R3: A write on the disable port clears each mask bit whose data bit is 1, one clock after the strobe. Mask bits whose data bit is 0 keep their value.
- R4: If the enable and disable ports are both written in the same cycle and both carry a 1 for the same bit, that mask bit ends up cleared.
- R5: An event pulse on a source sets its status bit one clock later, whether that source is masked or not. The bit stays set after the pulse ends.
- R6: A write on the status-clear port clears each status bit whose data bit is 1. Status bits whose data bit is 0 keep their value.
- R7: If an event arrives in the same cycle as a clearing write to the same status bit, the bit stays set.
- R8: The interrupt output is high exactly when at least one bit is set in both status and mask. Masking a latched source drops the line but keeps the status bit.
- R9: The source positions are fixed: 0 RX trigger level, 1 RX empty, 2 RX full, 3 TX empty, 4 TX full, 5 RX overrun, 6 RX framing error, 7 RX parity error, 8 RX timeout, 9 modem status change, 10 TX trigger, 11 TX nearly full, 12 TX overrun. For example, a clear value of 0x00E0 removes only the three RX error causes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| evt_i | input | 13 | One-cycle event pulses, one per source |
| en_wr_i | input | 1 | Write strobe for the set-only enable port |
| en_data_i | input | 13 | Enable data; a 1 sets that mask bit |
| dis_wr_i | input | 1 | Write strobe for the clear-only disable port |
| dis_data_i | input | 13 | Disable data; a 1 clears that mask bit |
| sts_wr_i | input | 1 | Write strobe for the status-clear port |
| sts_data_i | input | 13 | Status clear data; a 1 clears that status bit |
| mask_o | output | 13 | Read view of the current mask |
| status_o | output | 13 | Read view of the sticky status |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench goes after the same-cycle collisions. In one case an enable and a disable hit one bit together; a design that lets the enable win leaves that source armed. In the other case an event coincides with its own clear; a design that lets the clear win loses the event silently. It also checks that zero data bits on every write port leave state untouched. A design that loads the written value instead of merging it would wipe unrelated mask or status bits. Finally it latches a cause while it is masked and then unmasks it. A design that gates status capture with the mask would never raise the line, and one that ORs status without the mask would raise it too early.

// File: rtl/irq_bank_pkg.sv
`timescale 1ns/1ps
package irq_bank_pkg;

    localparam int SRC_COUNT = 13;

    // Fixed source positions; software decodes these bit indices.
    typedef enum int {
        SRC_RX_TRIG     = 0,
        SRC_RX_EMPTY    = 1,
        SRC_RX_FULL     = 2,
        SRC_TX_EMPTY    = 3,
        SRC_TX_FULL     = 4,
        SRC_RX_OVERRUN  = 5,
        SRC_RX_FRAMING  = 6,
        SRC_RX_PARITY   = 7,
        SRC_RX_TIMEOUT  = 8,
        SRC_MODEM_CHG   = 9,
        SRC_TX_TRIG     = 10,
        SRC_TX_NFULL    = 11,
        SRC_TX_OVERRUN  = 12
    } src_pos_e;

    // Mask bit next state: clear has priority over set.
    function automatic logic mask_bit_next(logic cur, logic set_b, logic clr_b);
        logic nxt;
        nxt = cur;
        if (set_b) nxt = 1'b1;
        if (clr_b) nxt = 1'b0;
        return nxt;
    endfunction

    // Sticky bit next state: an arriving event has priority over a clear.
    function automatic logic sticky_bit_next(logic cur, logic evt_b, logic clr_b);
        logic nxt;
        nxt = cur;
        if (clr_b) nxt = 1'b0;
        if (evt_b) nxt = 1'b1;
        return nxt;
    endfunction

endpackage

// File: rtl/irq_mask_reg.sv
`timescale 1ns/1ps
module irq_mask_reg #(
    parameter int SRC_W = irq_bank_pkg::SRC_COUNT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             set_wr_i,
    input  logic [SRC_W-1:0] set_data_i,
    input  logic             clr_wr_i,
    input  logic [SRC_W-1:0] clr_data_i,
    output logic [SRC_W-1:0] mask_o
);
    import irq_bank_pkg::*;

    logic [SRC_W-1:0] set_vec;
    logic [SRC_W-1:0] clr_vec;

    assign set_vec = set_wr_i ? set_data_i : '0;
    assign clr_vec = clr_wr_i ? clr_data_i : '0;

    for (genvar b = 0; b < SRC_W; b++) begin : g_bit
        logic q;
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                q <= 1'b0;
            end else begin
                q <= mask_bit_next(q, set_vec[b], clr_vec[b]);
            end
        end
        assign mask_o[b] = q;
    end

endmodule

// File: rtl/irq_status_reg.sv
`timescale 1ns/1ps
module irq_status_reg #(
    parameter int SRC_W = irq_bank_pkg::SRC_COUNT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SRC_W-1:0] evt_i,
    input  logic             clr_wr_i,
    input  logic [SRC_W-1:0] clr_data_i,
    output logic [SRC_W-1:0] status_o
);
    import irq_bank_pkg::*;

    logic [SRC_W-1:0] clr_vec;

    assign clr_vec = clr_wr_i ? clr_data_i : '0;

    for (genvar b = 0; b < SRC_W; b++) begin : g_bit
        logic q;
        always_ff @(posedge clk_i) begin
            if (rst_i) begin
                q <= 1'b0;
            end else begin
                q <= sticky_bit_next(q, evt_i[b], clr_vec[b]);
            end
        end
        assign status_o[b] = q;
    end

endmodule

// File: rtl/irq_combine.sv
`timescale 1ns/1ps
module irq_combine #(
    parameter int SRC_W = irq_bank_pkg::SRC_COUNT
) (
    input  logic [SRC_W-1:0] status_i,
    input  logic [SRC_W-1:0] mask_i,
    output logic             irq_o
);
    logic [SRC_W-1:0] pending;

    assign pending = status_i & mask_i;
    assign irq_o   = |pending;

endmodule

// File: rtl/irq_bank.sv
`timescale 1ns/1ps
module irq_bank #(
    parameter int SRC_W = irq_bank_pkg::SRC_COUNT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [SRC_W-1:0] evt_i,
    input  logic             en_wr_i,
    input  logic [SRC_W-1:0] en_data_i,
    input  logic             dis_wr_i,
    input  logic [SRC_W-1:0] dis_data_i,
    input  logic             sts_wr_i,
    input  logic [SRC_W-1:0] sts_data_i,
    output logic [SRC_W-1:0] mask_o,
    output logic [SRC_W-1:0] status_o,
    output logic             irq_o
);
    logic [SRC_W-1:0] mask_q;
    logic [SRC_W-1:0] status_q;

    irq_mask_reg #(.SRC_W(SRC_W)) u_mask (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .set_wr_i   (en_wr_i),
        .set_data_i (en_data_i),
        .clr_wr_i   (dis_wr_i),
        .clr_data_i (dis_data_i),
        .mask_o     (mask_q)
    );

    irq_status_reg #(.SRC_W(SRC_W)) u_status (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .evt_i      (evt_i),
        .clr_wr_i   (sts_wr_i),
        .clr_data_i (sts_data_i),
        .status_o   (status_q)
    );

    irq_combine #(.SRC_W(SRC_W)) u_comb (
        .status_i (status_q),
        .mask_i   (mask_q),
        .irq_o    (irq_o)
    );

    assign mask_o   = mask_q;
    assign status_o = status_q;

endmodule

// File: rtl/irq_bank_chk.sv
`timescale 1ns/1ps
module irq_bank_chk #(
    parameter int SRC_W = irq_bank_pkg::SRC_COUNT
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [SRC_W-1:0] evt_i,
    input logic             en_wr_i,
    input logic [SRC_W-1:0] en_data_i,
    input logic             dis_wr_i,
    input logic [SRC_W-1:0] dis_data_i,
    input logic             sts_wr_i,
    input logic [SRC_W-1:0] sts_data_i,
    input logic [SRC_W-1:0] mask_o,
    input logic [SRC_W-1:0] status_o,
    input logic             irq_o
);

    // R2: enabled bits are set after an enable write without a disable
    assert_en_sets_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (en_wr_i && !dis_wr_i) |=> ((mask_o & $past(en_data_i)) == $past(en_data_i)));

    // R2/R3: with no mask write the mask holds
    assert_mask_hold_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_wr_i && !dis_wr_i) |=> $stable(mask_o));

    // R3, R4: disabled bits are clear afterwards, even with a same-cycle enable
    assert_dis_clears_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        dis_wr_i |=> ((mask_o & $past(dis_data_i)) == '0));

    // R5, R7: an event always leaves its status bit set
    assert_evt_sets_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (|evt_i) |=> ((status_o & $past(evt_i)) == $past(evt_i)));

    // R6: cleared bits without a coinciding event are zero afterwards
    assert_clr_works_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        sts_wr_i |=> ((status_o & $past(sts_data_i & ~evt_i)) == '0));

    // R5/R6: with no event and no clear the status holds
    assert_status_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!sts_wr_i && evt_i == '0) |=> $stable(status_o));

endmodule

bind irq_bank irq_bank_chk #(.SRC_W(SRC_W)) chk_i (.*);

// File: tb/irq_bank_tb_top.sv
`timescale 1ns/1ps
module irq_bank_tb_top;
    import irq_bank_pkg::*;

    localparam int W = SRC_COUNT;
    localparam int WATCHDOG_NS = 100000;

    logic         clk_i = 1'b0;
    logic         rst_i;
    logic [W-1:0] evt_i;
    logic         en_wr_i;
    logic [W-1:0] en_data_i;
    logic         dis_wr_i;
    logic [W-1:0] dis_data_i;
    logic         sts_wr_i;
    logic [W-1:0] sts_data_i;
    logic [W-1:0] mask_o;
    logic [W-1:0] status_o;
    logic         irq_o;

    int checks   = 0;
    int failures = 0;
    logic [W-1:0] exp_mask;
    logic [W-1:0] exp_sts;
    bit done = 0;

    always #2 clk_i = ~clk_i;

    irq_bank #(.SRC_W(W)) dut_i (.*);

    task automatic check(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%04h expected=0x%04h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        check(req, "mask",   mask_o,   exp_mask);
        check(req, "status", status_o, exp_sts);
        check(req, "irq",    {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, |(exp_sts & exp_mask)});
    endtask

    // One bus cycle: drive at negedge, update model, sample 1 ns after posedge.
    task automatic step(string req,
                        logic en_w, logic [W-1:0] en_d,
                        logic dis_w, logic [W-1:0] dis_d,
                        logic clr_w, logic [W-1:0] clr_d,
                        logic [W-1:0] evt);
        @(negedge clk_i);
        en_wr_i = en_w;  en_data_i = en_d;
        dis_wr_i = dis_w; dis_data_i = dis_d;
        sts_wr_i = clr_w; sts_data_i = clr_d;
        evt_i = evt;
        exp_mask = (exp_mask | (en_w ? en_d : '0)) & ~(dis_w ? dis_d : '0);
        exp_sts  = (exp_sts & ~(clr_w ? clr_d : '0)) | evt;
        @(posedge clk_i);
        #1;
        en_wr_i = 0; dis_wr_i = 0; sts_wr_i = 0; evt_i = '0;
        en_data_i = '0; dis_data_i = '0; sts_data_i = '0;
        check_all(req);
    endtask

    task automatic idle(string req);
        step(req, 0, '0, 0, '0, 0, '0, '0);
    endtask

    task automatic do_reset();
        @(negedge clk_i);
        rst_i = 1;
        @(negedge clk_i);
        @(negedge clk_i);
        rst_i = 0;
        exp_mask = '0;
        exp_sts  = '0;
        check_all("R1");
    endtask

    task automatic t_reset();
        // R1: dirty state then reset
        step("R1", 1, 13'h1FFF, 0, '0, 0, '0, 13'h0F0F);
        do_reset();
        check("R1", "irq low", {{(W-1){1'b0}}, irq_o}, '0);
    endtask

    task automatic t_enable();
        step("R2", 1, 13'h0005, 0, '0, 0, '0, '0);
        step("R2", 1, 13'h0100, 0, '0, 0, '0, '0);
        check("R2", "mask merge", mask_o, 13'h0105);
        step("R2", 1, 13'h0000, 0, '0, 0, '0, '0);
        check("R2", "zero enable", mask_o, 13'h0105);
    endtask

    task automatic t_disable();
        step("R3", 0, '0, 1, 13'h0004, 0, '0, '0);
        check("R3", "mask after disable", mask_o, 13'h0101);
        step("R3", 0, '0, 1, 13'h0000, 0, '0, '0);
        check("R3", "zero disable", mask_o, 13'h0101);
    endtask

    task automatic t_conflict();
        step("R4", 1, 13'h0030, 1, 13'h0010, 0, '0, '0);
        check("R4", "disable wins", mask_o, 13'h0121);
    endtask

    task automatic t_sticky_masked();
        step("R5", 0, '0, 0, '0, 0, '0, 13'h1 << SRC_TX_EMPTY);
        check("R5", "masked event latched", status_o, 13'h0008);
        check("R8", "masked source no irq", {{(W-1){1'b0}}, irq_o}, '0);
        idle("R5");
        check("R5", "sticky after pulse", status_o, 13'h0008);
        step("R8", 1, 13'h1 << SRC_TX_EMPTY, 0, '0, 0, '0, '0);
        check("R8", "unmask raises irq", {{(W-1){1'b0}}, irq_o}, 13'h1);
        step("R8", 0, '0, 1, 13'h1 << SRC_TX_EMPTY, 0, '0, '0);
        check("R8", "remask drops irq keeps status", status_o, 13'h0008);
    endtask

    task automatic t_rx_err_clear();
        step("R9", 0, '0, 0, '0, 0, '0,
             (13'h1 << SRC_RX_OVERRUN) | (13'h1 << SRC_RX_FRAMING) |
             (13'h1 << SRC_RX_PARITY)  | (13'h1 << SRC_RX_EMPTY) |
             (13'h1 << SRC_TX_OVERRUN));
        step("R6", 0, '0, 0, '0, 1, 13'h00E0, '0);
        check("R9", "only rx errors cleared", status_o, 13'h100A);
        step("R6", 0, '0, 0, '0, 1, 13'h0000, '0);
        check("R6", "zero clear keeps", status_o, 13'h100A);
    endtask

    task automatic t_collide();
        step("R7", 0, '0, 0, '0, 1, 13'h1002, 13'h1 << SRC_TX_OVERRUN);
        check("R7", "event beats clear", status_o, 13'h1008);
    endtask

    task automatic t_irq_live();
        step("R8", 0, '0, 0, '0, 0, '0, 13'h1 << SRC_RX_TRIG);
        check("R8", "enabled event irq", {{(W-1){1'b0}}, irq_o}, 13'h1);
        step("R8", 0, '0, 0, '0, 1, 13'h1FFF, '0);
        check("R8", "all cleared irq low", {{(W-1){1'b0}}, irq_o}, '0);
    endtask

    initial begin
        #(WATCHDOG_NS);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_i = 1;
        evt_i = '0;
        en_wr_i = 0;  en_data_i = '0;
        dis_wr_i = 0; dis_data_i = '0;
        sts_wr_i = 0; sts_data_i = '0;
        exp_mask = '0;
        exp_sts  = '0;
        repeat (3) @(negedge clk_i);
        rst_i = 0;
        check_all("R1");
        t_enable();
        t_disable();
        t_conflict();
        t_sticky_masked();
        t_rx_err_clear();
        t_collide();
        t_irq_live();
        t_reset();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule